// File: doc/BRIEF.md
# Rotate and Shift Unit with Condition Flags

This block is the 32-bit rotate/shift step of an integer execution pipe. It handles seven operations on one operand, selected by a 3-bit code: two plain rotates, two rotates that pass through the carry flag, a logical left shift, a logical right shift and an arithmetic right shift. Only the low five bits of the count are used. Alongside the operand it takes the six incoming arithmetic flags, and it returns the new flag set together with a write-enable mask. The mask shows which flags the operation changes.

A masked count of zero makes the operation do nothing: the operand passes through unchanged, the incoming flags are returned as they are, and the mask is empty. Rotates change only carry and overflow. Shifts rewrite all six flags. All outputs come from one register stage and are qualified by a valid strobe.

Top module: `rotshift_unit`

## Requirements
- R1: Only count bits 4:0 are used. Bits above them have no effect on the result, the flags or the mask.
- R2: When the masked count is 0, result equals the operand, flags_out equals flags_in and flag_we is 0, whatever the operation.
- R3: Op code 0 rotates left. The new carry is result bit 0, and overflow is the new carry XOR result bit 31.
- R4: Op code 1 rotates right. The new carry is result bit 31, and overflow is result bit 31 XOR result bit 30.
- R5: Op code 2 rotates the 33-bit value {carry, operand} left. The incoming carry lands at result bit count-1, the new carry is operand bit 32-count, and overflow is the new carry XOR result bit 31.
- R6: Op code 3 rotates the 33-bit value {carry, operand} right. The incoming carry lands at result bit 32-count, the new carry is operand bit count-1, and overflow is result bit 31 XOR result bit 30.
- R7: Op code 4 shifts left and fills with zeros. Carry is operand bit 32-count, and overflow is carry XOR result bit 31.
- R8: Op code 5 shifts right and fills with zeros. Carry is operand bit count-1, and overflow is result bit 31 XOR result bit 30. This makes overflow the old sign bit for a count of 1 and 0 for larger counts.
- R9: Op code 6 shifts right and copies the sign bit into the vacated positions. Carry is operand bit count-1, and overflow is 0.
- R10: For a shift with a nonzero count, sign is result bit 31, zero is set when the result is 0, parity is set when result bits 7:0 hold an even number of ones, and auxiliary carry is cleared.
- R11: The flag vector is {OF,SF,ZF,AF,PF,CF} at bits 5..0. flag_we is 6'b100001 for a rotate with a nonzero count and 6'b111111 for a shift with a nonzero count. A rotate returns SF, ZF, AF and PF unchanged from flags_in.
- R12: out_valid is in_valid delayed by one clock, and the other outputs reflect the input seen on that edge. While in_valid is low, result, flags_out and flag_we hold their values. After reset all outputs are 0.
- R13: Op code 7 is reserved and behaves like a zero count: result is the operand, the flags pass through and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 3 | Operation code 0..7 |
| operand | input | DATA_W (32) | Value to rotate or shift |
| count | input | CNT_IN_W (8) | Count; only bits 4:0 are used |
| flags_in | input | 6 | Incoming {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Registered result strobe |
| result | output | DATA_W (32) | Rotated or shifted value |
| flags_out | output | 6 | Updated {OF,SF,ZF,AF,PF,CF} |
| flag_we | output | 6 | Per-flag write enable, same bit order |

## Verification
A wrong carry selection shows up one clock after the request as a CF bit that disagrees with the operand bit the requirement names. The overflow bit then disagrees as well, because it is derived from that carry. A slip in the 33-bit through-carry rotation moves the incoming carry to the wrong result bit, and this is visible on the very next out_valid. A mis-decoded zero count or reserved code shows up in the same cycle as a nonzero flag_we or as flags that differ from flags_in. The bench sweeps every count for every operation, so an off-by-one at counts 1 or 31 cannot go unseen.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_RSV = 3'd7
  } rsu_op_e;

  // bit 5 .. bit 0 : OF SF ZF AF PF CF
  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } rsu_flags_t;

  localparam int FLAG_N = 6;
  localparam logic [FLAG_N-1:0] WE_NONE = 6'b000000;
  localparam logic [FLAG_N-1:0] WE_ROT  = 6'b100001;
  localparam logic [FLAG_N-1:0] WE_ALL  = 6'b111111;

  function automatic logic even_parity8(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/rsu_rotate_core.sv
module rsu_rotate_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              go_right,
  input  logic              through,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              cf_new,
  output logic              of_new
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   ext;
  logic [DATA_W:0]   ext_rot;
  logic [DATA_W-1:0] plain;
  int unsigned       back_plain;
  int unsigned       back_ext;

  always_comb begin
    back_plain = DATA_W - 32'(cnt);
    back_ext   = DATA_W + 1 - 32'(cnt);
    ext        = {carry_in, a};
    if (go_right) begin
      plain   = (a >> cnt) | (a << back_plain);
      ext_rot = (ext >> cnt) | (ext << back_ext);
    end else begin
      plain   = (a << cnt) | (a >> back_plain);
      ext_rot = (ext << cnt) | (ext >> back_ext);
    end
    if (through) begin
      res    = ext_rot[MSB:0];
      cf_new = ext_rot[DATA_W];
    end else begin
      res    = plain;
      cf_new = go_right ? plain[MSB] : plain[0];
    end
    of_new = go_right ? (res[MSB] ^ res[MSB-1]) : (cf_new ^ res[MSB]);
  end
endmodule

// File: rtl/rsu_shift_core.sv
module rsu_shift_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              go_right,
  input  logic              arith,
  output logic [DATA_W-1:0] res,
  output logic              cf_new,
  output logic              of_new
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] out_bits;

  always_comb begin
    if (!go_right) begin
      res      = a << cnt;
      out_bits = a >> (DATA_W - 32'(cnt));
      cf_new   = out_bits[0];
      of_new   = cf_new ^ res[MSB];
    end else begin
      if (arith) res = $unsigned($signed(a) >>> cnt);
      else       res = a >> cnt;
      out_bits = (cnt == '0) ? '0 : (a >> (32'(cnt) - 1));
      cf_new   = out_bits[0];
      of_new   = arith ? 1'b0 : (res[MSB] ^ res[MSB-1]);
    end
  end
endmodule

// File: rtl/rsu_flag_unit.sv
module rsu_flag_unit #(
  parameter int DATA_W = 32
) (
  input  logic                rot_act,
  input  logic                sh_act,
  input  rsu_pkg::rsu_flags_t fin,
  input  logic [DATA_W-1:0]   res,
  input  logic                cf_sel,
  input  logic                of_sel,
  output rsu_pkg::rsu_flags_t fout,
  output logic [rsu_pkg::FLAG_N-1:0] we
);
  import rsu_pkg::*;

  always_comb begin
    fout = fin;
    we   = WE_NONE;
    if (rot_act) begin
      fout.cf_f = cf_sel;
      fout.of_f = of_sel;
      we        = WE_ROT;
    end else if (sh_act) begin
      fout.cf_f = cf_sel;
      fout.of_f = of_sel;
      fout.sf_f = res[DATA_W-1];
      fout.zf_f = (res == '0);
      fout.pf_f = even_parity8(res[7:0]);
      fout.af_f = 1'b0;
      we        = WE_ALL;
    end
  end
endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op_sel,
  input  logic [DATA_W-1:0]   operand,
  input  logic [CNT_IN_W-1:0] count,
  input  logic [5:0]          flags_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [5:0]          flags_out,
  output logic [5:0]          flag_we
);
  import rsu_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  rsu_op_e          op;
  logic [CNT_W-1:0] cnt_eff;
  logic             cnt_zero_w;
  logic             is_rot_w;
  logic             is_shift_w;

  assign op         = rsu_op_e'(op_sel);
  assign cnt_eff    = count[CNT_W-1:0];
  assign cnt_zero_w = (cnt_eff == '0);
  assign is_rot_w   = !cnt_zero_w && (op inside {OP_ROL, OP_ROR, OP_RCL, OP_RCR});
  assign is_shift_w = !cnt_zero_w && (op inside {OP_SHL, OP_SHR, OP_SAR});

  rsu_flags_t        fin_s;
  rsu_flags_t        fout_s;
  logic [FLAG_N-1:0] we_s;
  assign fin_s = rsu_flags_t'(flags_in);

  logic [DATA_W-1:0] rot_res, sh_res, res_next;
  logic              rot_cf, rot_of, sh_cf, sh_of, cf_mux, of_mux;

  rsu_rotate_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) rot_i (
    .a        (operand),
    .cnt      (cnt_eff),
    .go_right (op == OP_ROR || op == OP_RCR),
    .through  (op == OP_RCL || op == OP_RCR),
    .carry_in (fin_s.cf_f),
    .res      (rot_res),
    .cf_new   (rot_cf),
    .of_new   (rot_of)
  );

  rsu_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) sh_i (
    .a        (operand),
    .cnt      (cnt_eff),
    .go_right (op == OP_SHR || op == OP_SAR),
    .arith    (op == OP_SAR),
    .res      (sh_res),
    .cf_new   (sh_cf),
    .of_new   (sh_of)
  );

  always_comb begin
    if (is_rot_w) begin
      res_next = rot_res;
      cf_mux   = rot_cf;
      of_mux   = rot_of;
    end else if (is_shift_w) begin
      res_next = sh_res;
      cf_mux   = sh_cf;
      of_mux   = sh_of;
    end else begin
      res_next = operand;
      cf_mux   = fin_s.cf_f;
      of_mux   = fin_s.of_f;
    end
  end

  rsu_flag_unit #(.DATA_W(DATA_W)) flg_i (
    .rot_act (is_rot_w),
    .sh_act  (is_shift_w),
    .fin     (fin_s),
    .res     (res_next),
    .cf_sel  (cf_mux),
    .of_sel  (of_mux),
    .fout    (fout_s),
    .we      (we_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      flag_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_next;
        flags_out <= fout_s;
        flag_we   <= we_s;
      end
    end
  end
endmodule

// File: rtl/rotshift_unit_chk.sv
module rotshift_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          op_sel,
  input logic [DATA_W-1:0]   operand,
  input logic [CNT_IN_W-1:0] count,
  input logic [5:0]          flags_in,
  input logic                out_valid,
  input logic [DATA_W-1:0]   result,
  input logic [5:0]          flags_out,
  input logic [5:0]          flag_we,
  input logic                cnt_zero_w,
  input logic                is_rot_w,
  input logic                is_shift_w
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int MSB   = DATA_W - 1;

  logic nz;
  assign nz = (count[CNT_W-1:0] != '0);

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flags_out));

  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !nz |=> result == $past(operand) && flags_out == $past(flags_in) && flag_we == 6'b0);
  a_r1_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !nz && (count[CNT_IN_W-1:CNT_W] != '0) |=> flag_we == 6'b0);

  a_r3_rol_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nz && op_sel == 3'd0 |=> flags_out[0] == result[0] && flags_out[5] == (result[0] ^ result[MSB]));
  a_r4_ror_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nz && op_sel == 3'd1 |=> flags_out[0] == result[MSB] && flags_out[5] == (result[MSB] ^ result[MSB-1]));
  a_r9_sar_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nz && op_sel == 3'd6 |=> !flags_out[5] && result[MSB] == $past(operand[MSB]));
  a_r10_shift_status: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_shift_w |=> flags_out[4] == result[MSB] && flags_out[3] == (result == '0) && !flags_out[2] && flag_we == 6'b111111);
  a_r11_rotate_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_rot_w |=> flag_we == 6'b100001 && flags_out[4:1] == $past(flags_in[4:1]));
  a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == 3'd7 |=> flag_we == 6'b0 && result == $past(operand));
  a_r11_decode_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_rot_w, is_shift_w, cnt_zero_w}) <= 1);
endmodule

bind rotshift_unit rotshift_unit_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .operand    (operand),
  .count      (count),
  .flags_in   (flags_in),
  .out_valid  (out_valid),
  .result     (result),
  .flags_out  (flags_out),
  .flag_we    (flag_we),
  .cnt_zero_w (cnt_zero_w),
  .is_rot_w   (is_rot_w),
  .is_shift_w (is_shift_w)
);

// File: tb/rotshift_unit_tb_top.sv
`timescale 1ns/1ps
module rotshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] operand = '0;
  logic [7:0]  count = '0;
  logic [5:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags_out;
  logic [5:0]  flag_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rotshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .count(count), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out), .flag_we(flag_we)
  );

  // behavioural model: one bit position per step
  logic [31:0] m_res;
  logic [5:0]  m_flg;
  logic [5:0]  m_we;

  task automatic model(input int op, input int cnt8, input logic [31:0] v0, input logic [5:0] f0);
    int c = cnt8 % 32;
    logic [31:0] v = v0;
    logic cf = f0[0];
    logic b;
    m_flg = f0;
    m_we  = 6'b0;
    if (c != 0 && op < 7) begin
      for (int i = 0; i < c; i++) begin
        case (op)
          0: begin b = v[31]; v = {v[30:0], b}; cf = b; end
          1: begin b = v[0];  v = {b, v[31:1]}; cf = b; end
          2: begin b = v[31]; v = {v[30:0], cf}; cf = b; end
          3: begin b = v[0];  v = {cf, v[31:1]}; cf = b; end
          4: begin cf = v[31]; v = {v[30:0], 1'b0}; end
          5: begin cf = v[0];  v = {1'b0, v[31:1]}; end
          default: begin cf = v[0]; v = {v[31], v[31:1]}; end
        endcase
      end
      m_flg[0] = cf;
      if (op == 0 || op == 2 || op == 4) m_flg[5] = cf ^ v[31];
      else if (op == 6)                  m_flg[5] = 1'b0;
      else                               m_flg[5] = v[31] ^ v[30];
      if (op >= 4) begin
        m_flg[4] = v[31];
        m_flg[3] = (v == 0);
        m_flg[2] = 1'b0;
        m_flg[1] = ~^v[7:0];
        m_we = 6'b111111;
      end else m_we = 6'b100001;
    end
    m_res = v;
  endtask

  function automatic string tag(input int op, input int cnt8);
    if (cnt8 % 32 == 0) return "R2";
    case (op)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R13";
    endcase
  endfunction

  task automatic chk32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int op, input int cnt8, input logic [31:0] v, input logic [5:0] f, input string req_over);
    string rq, rqf, rqm;
    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'(op); count = 8'(cnt8); operand = v; flags_in = f;
    model(op, cnt8, v, f);
    @(negedge clk);
    rq  = (req_over != "") ? req_over : tag(op, cnt8);
    rqf = (req_over == "" && op >= 4 && op < 7 && cnt8 % 32 != 0) ? "R10" : rq;
    rqm = (req_over == "" && op < 7 && cnt8 % 32 != 0) ? "R11" : rq;
    chk32("R12", "out_valid", 32'(out_valid), 32'd1);
    chk32(rq, "result", result, m_res);
    chk32(rq, "CF/OF", {30'b0, flags_out[5], flags_out[0]}, {30'b0, m_flg[5], m_flg[0]});
    chk32(rqf, "SF/ZF/AF/PF", 32'(flags_out[4:1]), 32'(m_flg[4:1]));
    chk32(rqm, "flag_we", 32'(flag_we), 32'(m_we));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ops_v [5];
    logic [31:0] held;
    ops_v[0] = 32'h8000_0001; ops_v[1] = 32'h4F3C_A5E1; ops_v[2] = 32'h0000_0000;
    ops_v[3] = 32'hFFFF_FFFF; ops_v[4] = 32'h7FFF_FFFE;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk32("R12", "reset out_valid", 32'(out_valid), 0);
    chk32("R12", "reset result", result, 0);
    chk32("R12", "reset flags", 32'({flags_out, flag_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk32("R12", "idle out_valid", 32'(out_valid), 0);

    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 5; k++)
        for (int c = 0; c < 32; c++)
          apply(op, c, ops_v[k] ^ (32'(c) << 11), 6'((c * 7 + k * 13 + op) % 64), "");

    // R1: upper count bits must be ignored
    for (int c = 32; c < 256; c += 37)
      for (int op = 0; op < 8; op++)
        apply(op, c, 32'hC3A5_0F96 + 32'(c), 6'(c % 64), "R1");

    // R12: outputs hold while in_valid is low
    @(negedge clk);
    held = result;
    in_valid = 1'b0; operand = 32'h1234_5678; count = 8'd3; op_sel = 3'd4;
    @(negedge clk);
    chk32("R12", "out_valid drop", 32'(out_valid), 0);
    chk32("R12", "hold result", result, held);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule